// File: doc/BRIEF.md
# Pixel output blanking pipeline

This block sits at the digital output of an image sensor front end. Every pixel clock it takes one 12-bit sample together with three active-high strobes: a blanking request and two clamp requests, one for optical-black pixels and one for dummy pixels. It returns that sample on its output port a fixed nine clock edges later. The strobes travel through the same stages as the sample, so any decision they make lands on the pixel they were issued with.

A pixel that arrives with blanking set leaves as an all-zero word. Either clamp strobe cancels blanking for that pixel, because the clamp loop downstream needs the real black level. A delayed OR of the two clamp strobes comes out with the word for that loop's use. A valid flag rises once the stages hold real samples after reset and then stays high.

Top module: `pix_blank_pipe`

## Requirements
- R1: A sample taken at clock edge n appears on `pix_o` directly after edge n+8. This is nine register stages, counting edge n. Every edge produces one output word.
- R2: If `blank_i` is 1 and both clamp strobes are 0 when a sample is taken, that pixel's output word is all zeros.
- R3: If `blank_i` and `clamp_ob_i` are both 1 for a pixel, blanking is ignored and the sample passes unchanged.
- R4: If `blank_i` and `clamp_dm_i` are both 1 for a pixel, blanking is ignored and the sample passes unchanged.
- R5: With `blank_i` at 0, the sample passes unchanged, whatever the clamp strobes are.
- R6: `clamp_act_o` is 1 exactly when either clamp strobe was 1 for the pixel that is now on `pix_o`.
- R7: While `rst_ni` is 0, `pix_o` is 0, `clamp_act_o` is 0 and `valid_o` is 0. This holds for a reset at any time, including in the middle of a run.
- R8: `valid_o` rises directly after the ninth edge after reset release, which is the edge that presents the first sample. It then stays 1 until the next reset.
- R9: While `valid_o` is 0, `pix_o` and `clamp_act_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_i | input | DATA_W (12) | Sample word |
| blank_i | input | 1 | Blanking request for this pixel |
| clamp_ob_i | input | 1 | Optical-black clamp request |
| clamp_dm_i | input | 1 | Dummy-pixel clamp request |
| pix_o | output | DATA_W (12) | Delayed, gated sample word |
| clamp_act_o | output | 1 | Delayed clamp status aligned with `pix_o` |
| valid_o | output | 1 | Pipeline filled since reset |

## Verification
The hardest case to reach is a reset in the middle of a run. The stages hold live blanked and clamped pixels, and nine edges must then pass with zero output and a low valid flag before the first new sample appears. The stimulus fills the pipe with mixed strobe patterns and pulls reset while the pipe is still full. It then releases reset and drives fresh pixels at once. The scoreboard discards its queue during reset, so any stale word that leaks through is caught. Blanking that overlaps each clamp strobe is driven on the pixels next to the plain-blank pixels. A wrong stage for either the gating or the data therefore shows up as a zero or non-zero word on the wrong pixel.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  // Control qualifiers carried beside the sample word.
  typedef struct packed {
    logic blank;
    logic clamp;
  } pbp_ctl_t;

  localparam int CTL_W = $bits(pbp_ctl_t);

  // A clamp request cancels blanking for the same pixel.
  function automatic logic pbp_kill(pbp_ctl_t c);
    return c.blank & ~c.clamp;
  endfunction
endpackage

// File: rtl/pbp_delay_line.sv
module pbp_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] nxt;
    logic [W-1:0] cur;

    if (g == 0) begin : g_head
      always_comb nxt = d_i;
    end else begin : g_body
      always_comb nxt = g_stage[g-1].cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cur <= '0;
      else         cur <= nxt;
    end
  end

  assign q_o = g_stage[DEPTH-1].cur;
endmodule

// File: rtl/pbp_fill_tracker.sv
module pbp_fill_tracker #(
  parameter int LAT = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (!vld_q) begin
      if (cnt_q == LAST) vld_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign valid_o = vld_q;
endmodule

// File: rtl/pbp_out_gate.sv
module pbp_out_gate
  import pbp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tail_data_i,
  input  pbp_ctl_t          tail_ctl_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              clamp_act_o
);
  logic [DATA_W-1:0] pix_d, pix_q;
  logic              clp_d, clp_q;

  always_comb begin
    pix_d = pbp_kill(tail_ctl_i) ? '0 : tail_data_i;
    clp_d = tail_ctl_i.clamp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      clp_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      clp_q <= clp_d;
    end
  end

  assign pix_o       = pix_q;
  assign clamp_act_o = clp_q;
endmodule

// File: rtl/pix_blank_pipe.sv
module pix_blank_pipe
  import pbp_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int LATENCY = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              blank_i,
  input  logic              clamp_ob_i,
  input  logic              clamp_dm_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              clamp_act_o,
  output logic              valid_o
);
  // One stage is the gated output register; the rest form the delay line.
  localparam int LINE_DEPTH = LATENCY - 1;
  localparam int BUS_W      = DATA_W + CTL_W;

  pbp_ctl_t          head_ctl;
  logic [BUS_W-1:0]  head_bus;
  logic [BUS_W-1:0]  tail_bus;
  pbp_ctl_t          tail_ctl;
  logic [DATA_W-1:0] tail_data;
  logic              tail_blank;
  logic              tail_clamp;

  always_comb begin
    head_ctl.blank = blank_i;
    head_ctl.clamp = clamp_ob_i | clamp_dm_i;
    head_bus       = {head_ctl, pix_i};
  end

  pbp_delay_line #(
    .W     (BUS_W),
    .DEPTH (LINE_DEPTH)
  ) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (head_bus),
    .q_o    (tail_bus)
  );

  always_comb begin
    tail_data  = tail_bus[DATA_W-1:0];
    tail_ctl   = pbp_ctl_t'(tail_bus[BUS_W-1:DATA_W]);
    tail_blank = tail_ctl.blank;
    tail_clamp = tail_ctl.clamp;
  end

  pbp_out_gate #(
    .DATA_W (DATA_W)
  ) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tail_data_i (tail_data),
    .tail_ctl_i  (tail_ctl),
    .pix_o       (pix_o),
    .clamp_act_o (clamp_act_o)
  );

  pbp_fill_tracker #(
    .LAT (LATENCY)
  ) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/pix_blank_pipe_chk.sv
module pix_blank_pipe_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] tail_data,
  input logic              tail_blank,
  input logic              tail_clamp,
  input logic [DATA_W-1:0] pix_o,
  input logic              clamp_act_o,
  input logic              valid_o
);
  assert_blank_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_blank && !tail_clamp) |=> (pix_o == '0));

  // A clamp (optical-black or dummy) overrides blanking.
  assert_clamp_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_clamp |=> (pix_o == $past(tail_data)));

  assert_clear_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tail_blank |=> (pix_o == $past(tail_data)));

  assert_clamp_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_clamp |=> clamp_act_o);

  assert_clamp_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tail_clamp |=> !clamp_act_o);

  assert_valid_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (pix_o == '0 && !clamp_act_o));
endmodule

bind pix_blank_pipe pix_blank_pipe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tail_data   (tail_data),
  .tail_blank  (tail_blank),
  .tail_clamp  (tail_clamp),
  .pix_o       (pix_o),
  .clamp_act_o (clamp_act_o),
  .valid_o     (valid_o)
);

// File: tb/test_pix_blank_pipe.sv
module test_pix_blank_pipe;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] pix_in;
  logic          blank, cob, cdm;
  logic [DW-1:0] pix_out;
  logic          clamp_act, valid;

  int errors = 0;
  int checks = 0;
  int edge_cnt = 0;
  bit finished = 0;

  typedef struct {
    int          e;
    logic [DW-1:0] d;
    logic        c;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  pix_blank_pipe i_pix_blank_pipe (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_i       (pix_in),
    .blank_i     (blank),
    .clamp_ob_i  (cob),
    .clamp_dm_i  (cdm),
    .pix_o       (pix_out),
    .clamp_act_o (clamp_act),
    .valid_o     (valid)
  );

  always @(posedge clk) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: inputs set at a falling edge, then wait one cycle.
  task automatic drive_px(input logic [DW-1:0] d, input logic b, input logic o, input logic m);
    exp_t it;
    pix_in = d; blank = b; cob = o; cdm = m;
    it.e   = edge_cnt;
    it.d   = (b && !o && !m) ? '0 : d;
    it.c   = o | m;
    it.tag = (b && o) ? "R3" : (b && m) ? "R4" : b ? "R2" : "R5";
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pix_in = '0; blank = 0; cob = 0; cdm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst_n) begin
        check(pix_out == '0, "R7 data", pix_out, 0);
        check(clamp_act == 1'b0, "R7 clamp", clamp_act, 0);
        check(valid == 1'b0, "R7 valid", valid, 0);
        sb.delete();
      end else begin
        automatic int last = edge_cnt - 1;
        automatic bit exp_v = (last >= 8);
        check(valid == exp_v, "R8 valid", valid, exp_v);
        if (exp_v) begin
          if (sb.size() > 0 && sb[0].e + 8 == last) begin
            automatic exp_t it = sb.pop_front();
            check(pix_out == it.d, {"R1/", it.tag}, pix_out, it.d);
            check(clamp_act == it.c, "R6", clamp_act, it.c);
          end else begin
            check(1'b0, "R1 no pixel due", last, 0);
          end
        end else begin
          check(pix_out == '0 && clamp_act == 1'b0, "R9", pix_out, 0);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    pix_in = '0; blank = 0; cob = 0; cdm = 0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    // R5: plain pass-through, varied data
    for (int i = 0; i < 12; i++) drive_px(DW'(12'h5A3 ^ (i * 37)), 0, 0, 0);
    // R2: blanking alone
    for (int i = 0; i < 5; i++) drive_px(DW'(12'hFFF - i), 1, 0, 0);
    // R3: blank with optical-black clamp
    for (int i = 0; i < 4; i++) drive_px(DW'(12'h321 + i), 1, 1, 0);
    drive_px(12'hABC, 1, 0, 0);
    // R4: blank with dummy clamp
    for (int i = 0; i < 4; i++) drive_px(DW'(12'h800 + i * 3), 1, 0, 1);
    // R6: clamps without blank, and both clamps
    drive_px(12'h111, 0, 1, 0);
    drive_px(12'h222, 0, 0, 1);
    drive_px(12'h333, 0, 1, 1);
    drive_px(12'h444, 1, 1, 1);
    // alternating pattern
    for (int i = 0; i < 16; i++) drive_px(DW'(i * 251), i[0], i[1] & i[2], i[3] & ~i[0]);
    // R7: reset while the pipe is full of live pixels
    for (int i = 0; i < 5; i++) drive_px(DW'(12'h0F0 + i), i[0], 0, i[1]);
    do_reset();
    for (int i = 0; i < 14; i++) drive_px(DW'(12'h7E1 ^ (i * 91)), i[1], i[2] & i[0], 0);
    for (int i = 0; i < 10; i++) drive_px('0, 0, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule